// File: doc/BRIEF.md
# USB Serial Engine Command Port

This block is the register-side front end of a USB serial interface engine. A processor reaches the engine's internal state through one command code register. Each write to it carries a phase byte and a payload byte. A command phase names an operation. A following write phase supplies that operation's argument byte. A following read phase collects its result into a data register. Two single-cycle pulses go to the interrupt logic: one says a command or write phase has been taken, and the other says a read result is waiting.

Behind the port the block holds the device address and its enable, the configured flag, and the device status byte. It also keeps the per-endpoint flags that the packet logic and the command set share: buffer full, setup, overwritten, NAK seen, stall and disable. It carries out set address, configure, read and write of device status, select endpoint, set endpoint status, clear buffer and validate buffer. Bus events enter as plain pulses and levels.

The sequencer has four named states. S_IDLE waits for a command. S_WANT_WR waits for a write phase. S_WANT_RD waits for a read phase. S_WANT_ANY accepts either, and is used only by device status. A valid command phase, or an unknown one, is the transition "take command" from any state, and it leads to the state its code calls for. A matching write or read phase is the transition "complete" back to S_IDLE. Every other phase is a self-loop that changes nothing.

Top module: `sie_cmd_engine`

## Requirements
- R1: After reset the following are all zero: both pulses, the data register, the address and its enable, the configured and connect outputs, and every endpoint's stall and disable bits.
- R2: The phase field is `cmd_word[15:8]`: 0x05 is command, 0x01 is write and 0x02 is read. The payload is `cmd_word[23:16]`. The cycle after an accepted command or write phase, `cmd_empty` is high for one cycle. The cycle after an accepted read phase, `data_full` is high for one cycle and the result byte sits in `cmd_rdata[7:0]`, with bits 31:8 zero. A new command phase replaces one that is still pending.
- R3: These are ignored: a write phase with no pending command that expects one, a read phase with no pending command that expects one, a read phase whose payload differs from the pending command code, and any phase value other than 0x01, 0x02 or 0x05. An ignored phase raises no pulse and leaves `cmd_rdata` unchanged. A command phase with an unknown code raises `cmd_empty` and leaves nothing pending.
- R4: Command 0xD0 followed by a write sets `dev_addr` from data bits 6:0 and `dev_addr_en` from data bit 7.
- R5: Command 0xD8 followed by a write sets `dev_configured` from data bit 0 only.
- R6: Command 0xFE followed by a write sets connect from data bit 0. When it is followed by a read instead, it returns a status byte with connect in bit 0, connect changed in bit 1, suspend in bit 2, suspend changed in bit 3 and bus reset in bit 4. Bits 7:5 are zero.
- R7: Three events set bits in the status byte. `conn_drop` clears connect and sets connect changed. A change of `bus_suspend` sets suspend changed. `bus_reset` sets bus reset. A status read clears all three of these bits, but an event in the same cycle takes precedence.
- R8: Command 0x00+n, for n below NEP, selects endpoint n, and its read returns: full in bit 0, stalled in bit 1, setup in bit 2, overwritten in bit 3, NAK in bit 4, buffer 1 full in bit 5, and bit 6 always zero. This read clears that endpoint's NAK flag.
- R9: Command 0x40+n followed by a write sets endpoint n's stall from data bit 0 and its disable from data bit 5. Bit 6 has no effect. A zero data byte also clears full, setup, overwritten and NAK.
- R10: When a set-endpoint-status write to endpoint 0 or 1 has data bit 7 set, it stalls both endpoint 0 and endpoint 1.
- R11: Command 0xF2 followed by a read returns the selected endpoint's overwritten flag in bit 0, and then clears its full, setup and overwritten flags.
- R12: Command 0xFA sets the selected endpoint's full flag, and no read or write phase follows it.
- R13: A packet pulse on `ep_rx_pkt[n]` sets full and loads setup from `ep_rx_setup[n]`. If full was already set, it also sets overwritten. When endpoint n is disabled, the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command code register |
| cmd_word | input | 16 | Bits 23:8 of the command code register: payload in 23:16, phase in 15:8 |
| cmd_rdata | output | 32 | Command data register; result in bits 7:0 |
| cmd_empty | output | 1 | Pulse: command or write phase taken |
| data_full | output | 1 | Pulse: read result is in cmd_rdata |
| bus_reset | input | 1 | Pulse: bus reset seen |
| bus_suspend | input | 1 | Level: bus is suspended |
| conn_drop | input | 1 | Pulse: connection lost |
| ep_rx_pkt | input | NEP | Pulse per endpoint: packet has landed in its buffer |
| ep_rx_setup | input | NEP | Qualifies ep_rx_pkt as a setup packet |
| ep_nak | input | NEP | Pulse per endpoint: NAK was sent |
| dev_addr | output | 7 | Device address |
| dev_addr_en | output | 1 | Device enable |
| dev_configured | output | 1 | Configured flag |
| dev_connect | output | 1 | Soft-connect state |
| ep_stalled | output | NEP | Stall state per endpoint |
| ep_disabled | output | NEP | Disable state per endpoint |

## Verification
The bench sends phases that do not belong in the current state. These include a write or read with nothing pending, a read whose code does not match, a garbage phase, and a read after an unknown command. A sequencer that acted on these would raise stray pulses or overwrite the data register. It stresses the control-endpoint pair with a conditional stall followed by separate unstalls. A design that stalled only the named endpoint, or unstalled both together, would show the wrong stall mask. It also checks that reading the status byte clears the change bits exactly once, and that a second packet into a full buffer raises the overwritten flag. Finally, it checks that clear buffer reports the overwrite before it clears the flag. A wrong ordering would return zero.

// File: rtl/sie_cmd_pkg.sv
package sie_cmd_pkg;

    // phase field values
    localparam logic [7:0] PH_WRITE = 8'h01;
    localparam logic [7:0] PH_READ  = 8'h02;
    localparam logic [7:0] PH_CMD   = 8'h05;

    // command codes
    localparam logic [7:0] C_SET_ADDR   = 8'hD0;
    localparam logic [7:0] C_CONFIG     = 8'hD8;
    localparam logic [7:0] C_DEV_STAT   = 8'hFE;
    localparam logic [7:0] C_CLR_BUF    = 8'hF2;
    localparam logic [7:0] C_VAL_BUF    = 8'hFA;
    localparam logic [7:0] C_SETEP_BASE = 8'h40;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WANT_WR,
        S_WANT_RD,
        S_WANT_ANY
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADDR,
        OP_CONF,
        OP_DSTAT,
        OP_SEL,
        OP_SETEP,
        OP_CLR
    } pend_op_e;

endpackage

// File: rtl/sie_cmd_seq.sv
module sie_cmd_seq
    import sie_cmd_pkg::*;
#(
    parameter int NEP = 4,
    parameter int IW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [23:8]   cmd_word,
    input  logic [7:0]    dev_stat_byte,
    input  logic [7:0]    ep_sel_byte,
    input  logic [7:0]    ep_clr_byte,
    output logic          cmd_empty,
    output logic          data_full,
    output logic [31:0]   cmd_rdata,
    output logic          wr_addr,
    output logic          wr_conf,
    output logic          wr_dstat,
    output logic          rd_dstat,
    output logic          sel_go,
    output logic          sel_rd,
    output logic          setep_go,
    output logic          clr_rd,
    output logic          val_go,
    output logic [IW-1:0] op_idx,
    output logic [7:0]    op_byte
);

    localparam logic [7:0] NEP_B = 8'(NEP);

    logic [7:0] phase;
    logic [7:0] pay;
    assign phase   = cmd_word[15:8];
    assign pay     = cmd_word[23:16];
    assign op_byte = pay;

    seq_state_e    state, nxt_state;
    pend_op_e      pend_op, nxt_op;
    logic [7:0]    pend_code;
    logic [IW-1:0] pend_idx;

    // decode of the payload of a command phase
    seq_state_e cmd_state;
    pend_op_e   cmd_op;
    logic       cmd_val;

    always_comb begin
        cmd_state = S_IDLE;
        cmd_op    = OP_NONE;
        cmd_val   = 1'b0;
        if (pay == C_SET_ADDR) begin
            cmd_state = S_WANT_WR;
            cmd_op    = OP_ADDR;
        end else if (pay == C_CONFIG) begin
            cmd_state = S_WANT_WR;
            cmd_op    = OP_CONF;
        end else if (pay == C_DEV_STAT) begin
            cmd_state = S_WANT_ANY;
            cmd_op    = OP_DSTAT;
        end else if (pay == C_CLR_BUF) begin
            cmd_state = S_WANT_RD;
            cmd_op    = OP_CLR;
        end else if (pay == C_VAL_BUF) begin
            cmd_val   = 1'b1;
        end else if (pay < NEP_B) begin
            cmd_state = S_WANT_RD;
            cmd_op    = OP_SEL;
        end else if (pay >= C_SETEP_BASE && pay < (C_SETEP_BASE + NEP_B)) begin
            cmd_state = S_WANT_WR;
            cmd_op    = OP_SETEP;
        end
    end

    logic is_cmd, is_wr, is_rd;
    assign is_cmd = cmd_wr && (phase == PH_CMD);
    assign is_wr  = cmd_wr && (phase == PH_WRITE);
    assign is_rd  = cmd_wr && (phase == PH_READ) && (pay == pend_code);

    logic fire_empty, fire_full, wr_go, rd_go;

    always_comb begin
        nxt_state  = state;
        nxt_op     = pend_op;
        fire_empty = 1'b0;
        fire_full  = 1'b0;
        wr_go      = 1'b0;
        rd_go      = 1'b0;
        if (is_cmd) begin
            // take command: allowed from every state
            nxt_state  = cmd_state;
            nxt_op     = cmd_op;
            fire_empty = 1'b1;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_WANT_WR: begin
                    if (is_wr) begin
                        wr_go      = 1'b1;
                        fire_empty = 1'b1;
                        nxt_state  = S_IDLE;
                        nxt_op     = OP_NONE;
                    end
                end
                S_WANT_RD: begin
                    if (is_rd) begin
                        rd_go     = 1'b1;
                        fire_full = 1'b1;
                        nxt_state = S_IDLE;
                        nxt_op    = OP_NONE;
                    end
                end
                S_WANT_ANY: begin
                    if (is_wr) begin
                        wr_go      = 1'b1;
                        fire_empty = 1'b1;
                        nxt_state  = S_IDLE;
                        nxt_op     = OP_NONE;
                    end else if (is_rd) begin
                        rd_go     = 1'b1;
                        fire_full = 1'b1;
                        nxt_state = S_IDLE;
                        nxt_op    = OP_NONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_addr  = wr_go && (pend_op == OP_ADDR);
    assign wr_conf  = wr_go && (pend_op == OP_CONF);
    assign wr_dstat = wr_go && (pend_op == OP_DSTAT);
    assign setep_go = wr_go && (pend_op == OP_SETEP);
    assign rd_dstat = rd_go && (pend_op == OP_DSTAT);
    assign sel_rd   = rd_go && (pend_op == OP_SEL);
    assign clr_rd   = rd_go && (pend_op == OP_CLR);
    assign sel_go   = is_cmd && (cmd_op == OP_SEL);
    assign val_go   = is_cmd && cmd_val;
    assign op_idx   = sel_go ? pay[IW-1:0] : pend_idx;

    logic [7:0] rd_byte;
    always_comb begin
        rd_byte = 8'h00;
        if (pend_op == OP_DSTAT)    rd_byte = dev_stat_byte;
        else if (pend_op == OP_SEL) rd_byte = ep_sel_byte;
        else if (pend_op == OP_CLR) rd_byte = ep_clr_byte;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            pend_op   <= OP_NONE;
            pend_code <= 8'h00;
            pend_idx  <= '0;
        end else begin
            state   <= nxt_state;
            pend_op <= nxt_op;
            if (is_cmd) begin
                pend_code <= pay;
                pend_idx  <= pay[IW-1:0];
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_empty <= 1'b0;
            data_full <= 1'b0;
            cmd_rdata <= 32'h0;
        end else begin
            cmd_empty <= fire_empty;
            data_full <= fire_full;
            if (fire_full) cmd_rdata <= {24'h0, rd_byte};
        end
    end

endmodule

// File: rtl/sie_dev_regs.sv
module sie_dev_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_addr,
    input  logic       wr_conf,
    input  logic       wr_dstat,
    input  logic       rd_dstat,
    input  logic [7:0] op_byte,
    input  logic       bus_reset,
    input  logic       bus_suspend,
    input  logic       conn_drop,
    output logic [6:0] dev_addr,
    output logic       dev_addr_en,
    output logic       dev_configured,
    output logic       dev_connect,
    output logic [7:0] dev_stat_byte
);

    logic con_chg, sus_q, sus_chg, rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr       <= 7'h0;
            dev_addr_en    <= 1'b0;
            dev_configured <= 1'b0;
            dev_connect    <= 1'b0;
            con_chg        <= 1'b0;
            sus_q          <= 1'b0;
            sus_chg        <= 1'b0;
            rst_seen       <= 1'b0;
        end else begin
            if (wr_addr) begin
                dev_addr    <= op_byte[6:0];
                dev_addr_en <= op_byte[7];
            end
            if (wr_conf) dev_configured <= op_byte[0];

            if (conn_drop)     dev_connect <= 1'b0;
            else if (wr_dstat) dev_connect <= op_byte[0];

            if (conn_drop)     con_chg <= 1'b1;
            else if (rd_dstat) con_chg <= 1'b0;

            sus_q <= bus_suspend;
            if (bus_suspend != sus_q) sus_chg <= 1'b1;
            else if (rd_dstat)        sus_chg <= 1'b0;

            if (bus_reset)     rst_seen <= 1'b1;
            else if (rd_dstat) rst_seen <= 1'b0;
        end
    end

    assign dev_stat_byte = {3'b000, rst_seen, sus_chg, sus_q, con_chg, dev_connect};

endmodule

// File: rtl/sie_ep_bank.sv
module sie_ep_bank #(
    parameter int NEP = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_go,
    input  logic           sel_rd,
    input  logic           setep_go,
    input  logic           clr_rd,
    input  logic           val_go,
    input  logic [IW-1:0]  op_idx,
    input  logic [7:0]     op_byte,
    input  logic [NEP-1:0] ep_rx_pkt,
    input  logic [NEP-1:0] ep_rx_setup,
    input  logic [NEP-1:0] ep_nak,
    output logic [7:0]     ep_sel_byte,
    output logic [7:0]     ep_clr_byte,
    output logic [NEP-1:0] ep_stalled,
    output logic [NEP-1:0] ep_disabled
);

    logic [IW-1:0]  sel_idx;
    logic [NEP-1:0] full_v, setup_v, ovw_v, nak_v;
    logic           cnd_pair;

    // conditional stall addressed to either control endpoint
    assign cnd_pair = setep_go && op_byte[7] && (int'(op_idx) < 2);

    always_ff @(posedge clk) begin
        if (!rst_n)      sel_idx <= '0;
        else if (sel_go) sel_idx <= op_idx;
    end

    for (genvar i = 0; i < NEP; i++) begin : g_ep
        localparam bit IS_CTRL = (i < 2);
        logic hit, on_sel;
        logic full_r, setup_r, ovw_r, nak_r, stall_r, dis_r;

        assign hit    = setep_go && (op_idx == IW'(i));
        assign on_sel = (sel_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_r  <= 1'b0;
                setup_r <= 1'b0;
                ovw_r   <= 1'b0;
                nak_r   <= 1'b0;
                stall_r <= 1'b0;
                dis_r   <= 1'b0;
            end else begin
                if (ep_rx_pkt[i] && !dis_r) begin
                    if (full_r) ovw_r <= 1'b1;
                    full_r  <= 1'b1;
                    setup_r <= ep_rx_setup[i];
                end
                if (ep_nak[i])             nak_r <= 1'b1;
                else if (sel_rd && on_sel) nak_r <= 1'b0;
                if (clr_rd && on_sel) begin
                    full_r  <= 1'b0;
                    setup_r <= 1'b0;
                    ovw_r   <= 1'b0;
                end
                if (val_go && on_sel) full_r <= 1'b1;
                if (hit) begin
                    stall_r <= op_byte[0];
                    dis_r   <= op_byte[5];
                    if (op_byte == 8'h00) begin
                        full_r  <= 1'b0;
                        setup_r <= 1'b0;
                        ovw_r   <= 1'b0;
                        nak_r   <= 1'b0;
                    end
                end
                if (IS_CTRL && cnd_pair) stall_r <= 1'b1;
            end
        end

        assign full_v[i]      = full_r;
        assign setup_v[i]     = setup_r;
        assign ovw_v[i]       = ovw_r;
        assign nak_v[i]       = nak_r;
        assign ep_stalled[i]  = stall_r;
        assign ep_disabled[i] = dis_r;
    end

    assign ep_sel_byte = {1'b0, full_v[sel_idx], nak_v[sel_idx], ovw_v[sel_idx],
                          setup_v[sel_idx], ep_stalled[sel_idx], full_v[sel_idx]};
    assign ep_clr_byte = {7'h00, ovw_v[sel_idx]};

endmodule

// File: rtl/sie_cmd_engine.sv
module sie_cmd_engine #(
    parameter int NEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [23:8]    cmd_word,
    output logic [31:0]    cmd_rdata,
    output logic           cmd_empty,
    output logic           data_full,
    input  logic           bus_reset,
    input  logic           bus_suspend,
    input  logic           conn_drop,
    input  logic [NEP-1:0] ep_rx_pkt,
    input  logic [NEP-1:0] ep_rx_setup,
    input  logic [NEP-1:0] ep_nak,
    output logic [6:0]     dev_addr,
    output logic           dev_addr_en,
    output logic           dev_configured,
    output logic           dev_connect,
    output logic [NEP-1:0] ep_stalled,
    output logic [NEP-1:0] ep_disabled
);

    localparam int IW = (NEP > 2) ? $clog2(NEP) : 1;

    logic          wr_addr, wr_conf, wr_dstat, rd_dstat;
    logic          sel_go, sel_rd, setep_go, clr_rd, val_go;
    logic [IW-1:0] op_idx;
    logic [7:0]    op_byte, dev_stat_byte, ep_sel_byte, ep_clr_byte;

    sie_cmd_seq #(.NEP(NEP), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .dev_stat_byte(dev_stat_byte), .ep_sel_byte(ep_sel_byte), .ep_clr_byte(ep_clr_byte),
        .cmd_empty(cmd_empty), .data_full(data_full), .cmd_rdata(cmd_rdata),
        .wr_addr(wr_addr), .wr_conf(wr_conf), .wr_dstat(wr_dstat), .rd_dstat(rd_dstat),
        .sel_go(sel_go), .sel_rd(sel_rd), .setep_go(setep_go), .clr_rd(clr_rd),
        .val_go(val_go), .op_idx(op_idx), .op_byte(op_byte)
    );

    sie_dev_regs u_dev (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_conf(wr_conf),
        .wr_dstat(wr_dstat), .rd_dstat(rd_dstat), .op_byte(op_byte),
        .bus_reset(bus_reset), .bus_suspend(bus_suspend), .conn_drop(conn_drop),
        .dev_addr(dev_addr), .dev_addr_en(dev_addr_en), .dev_configured(dev_configured),
        .dev_connect(dev_connect), .dev_stat_byte(dev_stat_byte)
    );

    sie_ep_bank #(.NEP(NEP), .IW(IW)) u_ep (
        .clk(clk), .rst_n(rst_n), .sel_go(sel_go), .sel_rd(sel_rd), .setep_go(setep_go),
        .clr_rd(clr_rd), .val_go(val_go), .op_idx(op_idx), .op_byte(op_byte),
        .ep_rx_pkt(ep_rx_pkt), .ep_rx_setup(ep_rx_setup), .ep_nak(ep_nak),
        .ep_sel_byte(ep_sel_byte), .ep_clr_byte(ep_clr_byte),
        .ep_stalled(ep_stalled), .ep_disabled(ep_disabled)
    );

endmodule

// File: rtl/sie_cmd_engine_chk.sv
module sie_cmd_engine_chk #(
    parameter int NEP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_wr,
    input logic [23:8]    cmd_word,
    input logic [31:0]    cmd_rdata,
    input logic           cmd_empty,
    input logic           data_full,
    input logic [6:0]     dev_addr,
    input logic           dev_configured,
    input logic [NEP-1:0] ep_stalled
);

    p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_empty && data_full));

    p_full_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_full |-> $past(cmd_wr && cmd_word[15:8] == 8'h02));

    p_empty_after_cmd_or_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_empty |-> $past(cmd_wr && (cmd_word[15:8] == 8'h05 || cmd_word[15:8] == 8'h01)));

    p_rdata_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !data_full |-> $stable(cmd_rdata));

    p_addr_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_wr && cmd_word[15:8] == 8'h01) |-> $stable(dev_addr));

    p_cfg_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_wr && cmd_word[15:8] == 8'h01) |-> $stable(dev_configured));

    p_stall_rise_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ep_stalled & ~$past(ep_stalled)) != '0) |-> $past(cmd_wr && cmd_word[15:8] == 8'h01));

endmodule

bind sie_cmd_engine sie_cmd_engine_chk #(.NEP(NEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_rdata(cmd_rdata), .cmd_empty(cmd_empty), .data_full(data_full),
    .dev_addr(dev_addr), .dev_configured(dev_configured), .ep_stalled(ep_stalled)
);

// File: tb/sie_cmd_engine_tb.sv
module sie_cmd_engine_tb;

    localparam int NEP = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_wr = 1'b0;
    logic [23:8]    cmd_word = '0;
    logic [31:0]    cmd_rdata;
    logic           cmd_empty, data_full;
    logic           bus_reset = 1'b0, bus_suspend = 1'b0, conn_drop = 1'b0;
    logic [NEP-1:0] ep_rx_pkt = '0, ep_rx_setup = '0, ep_nak = '0;
    logic [6:0]     dev_addr;
    logic           dev_addr_en, dev_configured, dev_connect;
    logic [NEP-1:0] ep_stalled, ep_disabled;

    always #2 clk = ~clk;

    sie_cmd_engine #(.NEP(NEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_rdata(cmd_rdata), .cmd_empty(cmd_empty), .data_full(data_full),
        .bus_reset(bus_reset), .bus_suspend(bus_suspend), .conn_drop(conn_drop),
        .ep_rx_pkt(ep_rx_pkt), .ep_rx_setup(ep_rx_setup), .ep_nak(ep_nak),
        .dev_addr(dev_addr), .dev_addr_en(dev_addr_en), .dev_configured(dev_configured),
        .dev_connect(dev_connect), .ep_stalled(ep_stalled), .ep_disabled(ep_disabled)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // {phase, payload, expect empty, expect full, expect data byte}
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {8'h05, 8'hD0, 1'b1, 1'b0, 8'h00},
        {8'h01, 8'hA5, 1'b1, 1'b0, 8'h00},
        {8'h05, 8'hFE, 1'b1, 1'b0, 8'h00},
        {8'h02, 8'hFE, 1'b0, 1'b1, 8'h00},
        {8'h01, 8'h01, 1'b0, 1'b0, 8'h00},
        {8'h05, 8'hFE, 1'b1, 1'b0, 8'h00},
        {8'h01, 8'h01, 1'b1, 1'b0, 8'h00},
        {8'h05, 8'hFE, 1'b1, 1'b0, 8'h00},
        {8'h02, 8'hFE, 1'b0, 1'b1, 8'h01},
        {8'h05, 8'h41, 1'b1, 1'b0, 8'h00},
        {8'h01, 8'h01, 1'b1, 1'b0, 8'h00},
        {8'h05, 8'h01, 1'b1, 1'b0, 8'h00},
        {8'h02, 8'h01, 1'b0, 1'b1, 8'h02},
        {8'h02, 8'h01, 1'b0, 1'b0, 8'h00},
        {8'h05, 8'h99, 1'b1, 1'b0, 8'h00},
        {8'h02, 8'h99, 1'b0, 1'b0, 8'h00},
        {8'h03, 8'hD0, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    logic        s_e, s_f;
    logic [31:0] s_d;

    task automatic xact(input logic [7:0] ph, input logic [7:0] pay);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = {pay, ph};
        @(negedge clk);
        cmd_wr   = 1'b0;
        s_e = cmd_empty;
        s_f = data_full;
        s_d = cmd_rdata;
    endtask

    task automatic rd_sel(input logic [7:0] ep, input logic [7:0] exp, input string req);
        xact(8'h05, ep);
        xact(8'h02, ep);
        chk(s_f == 1'b1 && s_d == {24'h0, exp}, req, s_d, {24'h0, exp});
    endtask

    task automatic set_ep(input logic [7:0] ep, input logic [7:0] val);
        xact(8'h05, 8'h40 + ep);
        xact(8'h01, val);
    endtask

    task automatic rd_stat(input logic [7:0] exp, input string req);
        xact(8'h05, 8'hFE);
        xact(8'h02, 8'hFE);
        chk(s_f == 1'b1 && s_d == {24'h0, exp}, req, s_d, {24'h0, exp});
    endtask

    task automatic pulse_rx(input int ep, input bit setup);
        @(negedge clk);
        ep_rx_pkt[ep]   = 1'b1;
        ep_rx_setup[ep] = setup;
        @(negedge clk);
        ep_rx_pkt   = '0;
        ep_rx_setup = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_d;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cmd_empty == 0 && data_full == 0 && cmd_rdata == 0, "R1 flags/data", cmd_rdata, 0);
        chk({dev_addr, dev_addr_en, dev_configured, dev_connect} == 0, "R1 device regs",
            {dev_addr, dev_addr_en, dev_configured, dev_connect}, 0);
        chk(ep_stalled == 0 && ep_disabled == 0, "R1 endpoint regs", {ep_stalled, ep_disabled}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6 R8 R9: vector walk
        last_d = 32'h0;
        for (int k = 0; k < NV; k++) begin
            xact(VEC[k][25:18], VEC[k][17:10]);
            chk(s_e == VEC[k][9] && s_f == VEC[k][8], $sformatf("R2/R3 vec %0d flags", k),
                {s_e, s_f}, {VEC[k][9], VEC[k][8]});
            if (VEC[k][8]) last_d = {24'h0, VEC[k][7:0]};
            chk(s_d == last_d, $sformatf("R2/R3 vec %0d data", k), s_d, last_d);
        end

        // R4: address and enable from the table write of 0xA5
        chk(dev_addr == 7'h25 && dev_addr_en, "R4 address", {dev_addr_en, dev_addr}, 8'hA5);
        chk(dev_connect == 1'b1, "R6 connect set", dev_connect, 1);

        // R5: configure bit0 only
        xact(8'h05, 8'hD8); xact(8'h01, 8'h01);
        chk(dev_configured == 1'b1, "R5 configure on", dev_configured, 1);
        xact(8'h05, 8'hD8); xact(8'h01, 8'hFE);
        chk(dev_configured == 1'b0, "R5 configure off", dev_configured, 0);

        // R2: new command replaces pending one
        xact(8'h05, 8'hD0); xact(8'h05, 8'hD8); xact(8'h01, 8'h01);
        chk(dev_configured == 1'b1 && dev_addr == 7'h25, "R2 replace pending",
            {dev_configured, dev_addr}, {1'b1, 7'h25});

        // R7: change bits set by events, cleared by one read
        @(negedge clk); bus_reset = 1'b1; bus_suspend = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        repeat (2) @(negedge clk);
        rd_stat(8'h1D, "R7 events seen");
        rd_stat(8'h05, "R7 changes cleared");
        @(negedge clk); conn_drop = 1'b1;
        @(negedge clk); conn_drop = 1'b0;
        rd_stat(8'h06, "R7 connection drop");

        // R3: read code mismatch ignored
        xact(8'h05, 8'h02);
        xact(8'h02, 8'h03);
        chk(s_f == 1'b0 && s_e == 1'b0, "R3 mismatched read", {s_e, s_f}, 0);
        xact(8'h02, 8'h02);
        chk(s_f == 1'b1 && s_d == 0, "R3 matching read after mismatch", s_d, 0);

        // R9 R10: unstall, conditional stall of the control pair
        set_ep(8'h01, 8'h00);
        chk(ep_stalled == 4'b0000, "R9 unstall ep1", ep_stalled, 0);
        set_ep(8'h00, 8'h80);
        chk(ep_stalled == 4'b0011, "R10 conditional stall both", ep_stalled, 4'b0011);
        set_ep(8'h01, 8'h00);
        chk(ep_stalled == 4'b0001, "R10 unstall one of pair", ep_stalled, 4'b0001);
        set_ep(8'h00, 8'h00);
        chk(ep_stalled == 4'b0000, "R9 unstall ep0", ep_stalled, 0);
        set_ep(8'h03, 8'h40);
        chk(ep_stalled == 0 && ep_disabled == 0, "R9 bit6 no effect", {ep_stalled, ep_disabled}, 0);

        // R13 R8: packet arrival and overwrite
        pulse_rx(2, 1'b1);
        rd_sel(8'h02, 8'h25, "R8 R13 setup packet");
        pulse_rx(2, 1'b0);
        rd_sel(8'h02, 8'h29, "R13 overwrite");

        // R11: clear buffer
        xact(8'h05, 8'hF2); xact(8'h02, 8'hF2);
        chk(s_f && s_d == 32'h1, "R11 clear returns overwrite", s_d, 1);
        rd_sel(8'h02, 8'h00, "R11 flags cleared");

        // R12: validate
        rd_sel(8'h03, 8'h00, "R12 before validate");
        xact(8'h05, 8'hFA);
        chk(s_e == 1'b1, "R12 validate empty flag", s_e, 1);
        rd_sel(8'h03, 8'h21, "R12 full after validate");

        // R8: NAK sticky, cleared by select read
        @(negedge clk); ep_nak[3] = 1'b1;
        @(negedge clk); ep_nak = '0;
        rd_sel(8'h03, 8'h31, "R8 nak set");
        rd_sel(8'h03, 8'h21, "R8 nak cleared");

        // R9: zero write reinitialises
        set_ep(8'h03, 8'h00);
        rd_sel(8'h03, 8'h00, "R9 reinit");

        // R13: disabled endpoint ignores packets
        set_ep(8'h02, 8'h20);
        chk(ep_disabled == 4'b0100, "R9 disable", ep_disabled, 4'b0100);
        pulse_rx(2, 1'b1);
        rd_sel(8'h02, 8'h00, "R13 disabled ignores packet");
        set_ep(8'h02, 8'h00);
        chk(ep_disabled == 4'b0000, "R9 enable again", ep_disabled, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule